// File: doc/BRIEF.md
# Windowed Overlapping Register File

This block is the integer register file of a processor core whose procedure calls slide a register window rather than save registers to memory. Every port sees 32 logical registers. Behind them sits a larger physical array of 8 shared registers plus 16 registers per window. A current window pointer (CWP) picks which group of 16 physical registers the upper 24 logical numbers reach. The eight outgoing registers of one window are the same physical storage as the eight incoming registers of the window entered by a save, so a caller places arguments in its outs and the callee finds them in its ins without any copy.

Three window controls move the pointer. A save request and trap entry step it down by one, and a restore request steps it up by one, each wrapping at the window count. Trap entry also stores the interrupted program counter and next program counter into two locals of the window it enters. A per-window invalid mask, supplied from outside, guards every move. A move into a window marked invalid raises an overflow or underflow flag, and the pointer and the registers stay as they were. A spill or fill handler elsewhere then deals with that window.

Top module: `win_regfile`

## Requirements
- R1: Logical registers 0 to 7 are globals: one physical copy each, the same from every window position.
- R2: Logical register 0 reads as zero on both read ports, and writes to it are dropped.
- R3: Logical registers 16 to 23 (locals) and 24 to 31 (ins) select registers private to the current window, so a value written in one window is not seen at the same number in another.
- R4: Logical registers 8 to 15 (outs) of window w are the physical registers that logical 24 to 31 (ins) reach in window w-1 (modulo the window count), with the same low three address bits.
- R5: A save request moves the CWP to CWP-1 and a restore request moves it to CWP+1, both modulo the window count (from 0 a save goes to NWIN-1, and from NWIN-1 a restore goes to 0). The new CWP applies from the cycle after the request.
- R6: Trap entry moves the CWP down by one, like a save. At the same clock edge it writes trap_pc to logical 17 (local 1) and trap_npc to logical 18 (local 2) of the window it enters.
- R7: When a save or a trap entry targets a window whose invalid-mask bit is 1 (bit index = window number), overflow_o is 1 in that same cycle. The CWP does not change, and a trap writes no registers.
- R8: When a restore that is accepted by priority targets a window whose invalid-mask bit is 1, underflow_o is 1 in that same cycle and the CWP does not change.
- R9: A read of the physical register being written in the same cycle returns the old value. The new value appears from the next cycle.
- R10: When several controls arrive together, trap entry wins over save and save wins over restore. Only one move happens per cycle, and overflow_o and underflow_o are never both 1.
- R11: While reset is low, every register clears to zero, the CWP clears to 0 and both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| rd_addr_a | input | 5 | Logical address, read port A |
| rd_data_a | output | DW | Read data, port A (combinational) |
| rd_addr_b | input | 5 | Logical address, read port B |
| rd_data_b | output | DW | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical write address, mapped through the current CWP |
| wr_data | input | DW | Write data |
| save_i | input | 1 | Save request (window down) |
| restore_i | input | 1 | Restore request (window up) |
| trap_i | input | 1 | Trap entry request |
| trap_pc | input | DW | Program counter stored at trap entry |
| trap_npc | input | DW | Next program counter stored at trap entry |
| inval_mask | input | NWIN | One bit per window; 1 marks that window invalid |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| overflow_o | output | 1 | Save or trap blocked by an invalid window |
| underflow_o | output | 1 | Restore blocked by an invalid window |

## Verification
The read data and both flags are combinational. The bench samples them one time unit after it drives inputs at a falling edge, within the same cycle. A write, a trap store and a pointer move take effect at the next rising edge. The bench therefore checks them at the falling edge after that edge. It reads the register of the new window at that point and judges the aliasing of outs onto ins there. For a read and a write to the same register in one cycle, the read is checked before the edge and the register again after it.

// File: rtl/win_regfile_pkg.sv
package win_regfile_pkg;

   localparam int unsigned LADDR_W   = 5;
   localparam int unsigned GROUP_SZ  = 8;
   localparam int unsigned WIN_SLICE = 16;

   // Logical register groups, decoded from laddr[4:3]
   typedef enum logic [1:0] {
      GRP_GLOBAL = 2'd0,
      GRP_OUT    = 2'd1,
      GRP_LOCAL  = 2'd2,
      GRP_IN     = 2'd3
   } reg_group_e;

   // Logical slots written at trap entry
   localparam logic [LADDR_W-1:0] TRAP_PC_SLOT  = 5'd17;
   localparam logic [LADDR_W-1:0] TRAP_NPC_SLOT = 5'd18;

   // First physical register of window w's ins
   function automatic int unsigned win_base(input int unsigned w);
      return GROUP_SZ + WIN_SLICE * w;
   endfunction

endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
   import win_regfile_pkg::*;
#(
   parameter int unsigned NWIN = 8,
   parameter int unsigned CW   = 3,
   parameter int unsigned PW   = 8
) (
   input  logic [LADDR_W-1:0] laddr,
   input  logic [CW-1:0]      cwp,
   output logic [PW-1:0]      paddr
);

   logic [CW-1:0] cwp_below;
   logic [2:0]    slot;
   reg_group_e    grp;

   assign cwp_below = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
   assign slot      = laddr[2:0];
   assign grp       = reg_group_e'(laddr[4:3]);

   always_comb begin
      unique case (grp)
         GRP_GLOBAL: paddr = PW'(slot);
         GRP_OUT:    paddr = PW'(win_base(32'(cwp_below)) + 32'(slot));
         GRP_LOCAL:  paddr = PW'(win_base(32'(cwp)) + GROUP_SZ + 32'(slot));
         default:    paddr = PW'(win_base(32'(cwp)) + 32'(slot));
      endcase
   end

endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
   parameter int unsigned NWIN = 8,
   parameter int unsigned CW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_i,
   input  logic            restore_i,
   input  logic            trap_i,
   input  logic [NWIN-1:0] inval_mask,
   output logic [CW-1:0]   cwp,
   output logic [CW-1:0]   cwp_dn,
   output logic            trap_go,
   output logic            ovf,
   output logic            unf
);

   logic [CW-1:0] cwp_up;
   logic          go_down;
   logic          go_up;

   assign cwp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
   assign cwp_up = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;

   // trap over save over restore
   assign go_down = trap_i | save_i;
   assign go_up   = restore_i & ~go_down;
   assign ovf     = go_down & inval_mask[cwp_dn];
   assign unf     = go_up & inval_mask[cwp_up];
   assign trap_go = trap_i & ~ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cwp <= '0;
      else if (go_down && !ovf)  cwp <= cwp_dn;
      else if (go_up && !unf)    cwp <= cwp_up;
   end

endmodule

// File: rtl/wrf_reg_array.sv
module wrf_reg_array #(
   parameter int unsigned NPHYS = 136,
   parameter int unsigned DW    = 32,
   parameter int unsigned PW    = 8,
   parameter int unsigned NWP   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] ra_a,
   input  logic [PW-1:0] ra_b,
   output logic [DW-1:0] rd_a,
   output logic [DW-1:0] rd_b,
   input  logic          we [NWP],
   input  logic [PW-1:0] wa [NWP],
   input  logic [DW-1:0] wd [NWP]
);

   logic [DW-1:0] mem [NPHYS];

   // Entry 0 is never written, so it keeps its reset value of zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
      end else begin
         for (int p = 0; p < NWP; p++) begin
            if (we[p] && wa[p] != '0) mem[wa[p]] <= wd[p];
         end
      end
   end

   assign rd_a = mem[ra_a];
   assign rd_b = mem[ra_b];

endmodule

// File: rtl/win_regfile.sv
module win_regfile
   import win_regfile_pkg::*;
#(
   parameter int unsigned NWIN = 8,
   parameter int unsigned DW   = 32,
   localparam int unsigned CW    = $clog2(NWIN),
   localparam int unsigned NPHYS = GROUP_SZ + WIN_SLICE * NWIN,
   localparam int unsigned PW    = $clog2(NPHYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [4:0]      rd_addr_a,
   output logic [DW-1:0]   rd_data_a,
   input  logic [4:0]      rd_addr_b,
   output logic [DW-1:0]   rd_data_b,
   input  logic            wr_en,
   input  logic [4:0]      wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic            save_i,
   input  logic            restore_i,
   input  logic            trap_i,
   input  logic [DW-1:0]   trap_pc,
   input  logic [DW-1:0]   trap_npc,
   input  logic [NWIN-1:0] inval_mask,
   output logic [CW-1:0]   cwp_o,
   output logic            overflow_o,
   output logic            underflow_o
);

   localparam int unsigned NMAP = 5;  // rd a, rd b, wr, trap pc, trap npc
   localparam int unsigned NWP  = 3;

   if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
      $error("win_regfile: NWIN must lie in 2..32");
   end
   if (DW < 1) begin : g_bad_dw
      $error("win_regfile: DW must be positive");
   end

   logic [CW-1:0]      cwp;
   logic [CW-1:0]      cwp_dn;
   logic               trap_go;
   logic [LADDR_W-1:0] map_la  [NMAP];
   logic [CW-1:0]      map_cwp [NMAP];
   logic [PW-1:0]      map_pa  [NMAP];
   logic               w_en    [NWP];
   logic [PW-1:0]      w_pa    [NWP];
   logic [DW-1:0]      w_dat   [NWP];

   wrf_window_ctl #(.NWIN(NWIN), .CW(CW)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .save_i     (save_i),
      .restore_i  (restore_i),
      .trap_i     (trap_i),
      .inval_mask (inval_mask),
      .cwp        (cwp),
      .cwp_dn     (cwp_dn),
      .trap_go    (trap_go),
      .ovf        (overflow_o),
      .unf        (underflow_o)
   );

   // Ports 0..2 use the present window; trap slots use the window being entered
   assign map_la[0] = rd_addr_a;     assign map_cwp[0] = cwp;
   assign map_la[1] = rd_addr_b;     assign map_cwp[1] = cwp;
   assign map_la[2] = wr_addr;       assign map_cwp[2] = cwp;
   assign map_la[3] = TRAP_PC_SLOT;  assign map_cwp[3] = cwp_dn;
   assign map_la[4] = TRAP_NPC_SLOT; assign map_cwp[4] = cwp_dn;

   for (genvar g = 0; g < NMAP; g++) begin : g_map
      wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
         .laddr (map_la[g]),
         .cwp   (map_cwp[g]),
         .paddr (map_pa[g])
      );
   end

   assign w_en[0] = wr_en;   assign w_pa[0] = map_pa[2]; assign w_dat[0] = wr_data;
   assign w_en[1] = trap_go; assign w_pa[1] = map_pa[3]; assign w_dat[1] = trap_pc;
   assign w_en[2] = trap_go; assign w_pa[2] = map_pa[4]; assign w_dat[2] = trap_npc;

   wrf_reg_array #(.NPHYS(NPHYS), .DW(DW), .PW(PW), .NWP(NWP)) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .ra_a  (map_pa[0]),
      .ra_b  (map_pa[1]),
      .rd_a  (rd_data_a),
      .rd_b  (rd_data_b),
      .we    (w_en),
      .wa    (w_pa),
      .wd    (w_dat)
   );

   assign cwp_o = cwp;

endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
   parameter int unsigned NWIN = 8,
   parameter int unsigned DW   = 32,
   parameter int unsigned CW   = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [4:0]    rd_addr_a,
   input logic [DW-1:0] rd_data_a,
   input logic [4:0]    rd_addr_b,
   input logic [DW-1:0] rd_data_b,
   input logic          save_i,
   input logic          restore_i,
   input logic          trap_i,
   input logic [CW-1:0] cwp_o,
   input logic          overflow_o,
   input logic          underflow_o
);

   // R2: register zero reads zero on both ports
   a_r2_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr_a == 5'd0 |-> rd_data_a == '0);
   a_r2_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr_b == 5'd0 |-> rd_data_b == '0);

   // R5: accepted save steps down with wrap
   a_r5_save_dec: assert property (@(posedge clk) disable iff (!rst_n)
      save_i && !trap_i && !overflow_o |=>
      cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - 1'b1));

   // R5: accepted restore steps up with wrap
   a_r5_restore_inc: assert property (@(posedge clk) disable iff (!rst_n)
      restore_i && !save_i && !trap_i && !underflow_o |=>
      cwp_o == (($past(cwp_o) == CW'(NWIN - 1)) ? '0 : $past(cwp_o) + 1'b1));

   // R6 / R10: trap entry steps down regardless of save or restore
   a_r6_trap_dec: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i && !overflow_o |=>
      cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - 1'b1));

   // R7: blocked downward move keeps the pointer
   a_r7_hold_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> $stable(cwp_o));

   // R8: blocked restore keeps the pointer
   a_r8_hold_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |=> $stable(cwp_o));

   // R10: one move at most, so never both flags
   a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(overflow_o && underflow_o));

   // R7 / R8: flags only with a request
   a_r7_ovf_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> (save_i || trap_i));
   a_r8_unf_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |-> restore_i);

endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .DW(DW), .CW(CW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_addr_a   (rd_addr_a),
   .rd_data_a   (rd_data_a),
   .rd_addr_b   (rd_addr_b),
   .rd_data_b   (rd_data_b),
   .save_i      (save_i),
   .restore_i   (restore_i),
   .trap_i      (trap_i),
   .cwp_o       (cwp_o),
   .overflow_o  (overflow_o),
   .underflow_o (underflow_o)
);

// File: tb/win_regfile_tb_top.sv
`timescale 1ns/1ps
module win_regfile_tb_top;

   localparam int NWIN = 8;
   localparam int DW   = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [4:0]      rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
   logic [DW-1:0]   rd_data_a, rd_data_b, wr_data = '0;
   logic            wr_en = 1'b0, save_i = 1'b0, restore_i = 1'b0, trap_i = 1'b0;
   logic [DW-1:0]   trap_pc = '0, trap_npc = '0;
   logic [NWIN-1:0] inval_mask = '0;
   logic [2:0]      cwp_o;
   logic            overflow_o, underflow_o;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   win_regfile #(.NWIN(NWIN), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .save_i(save_i), .restore_i(restore_i), .trap_i(trap_i),
      .trap_pc(trap_pc), .trap_npc(trap_npc), .inval_mask(inval_mask),
      .cwp_o(cwp_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // op: 0 none, 1 save, 2 restore, 3 trap (trap_pc = data, trap_npc = data + 4)
   // fields: op[47:46] we[45] waddr[44:40] data[39:24] raddr[23:19] exp[18:3] cwp[2:0]
   localparam int NV = 15;
   localparam logic [47:0] VEC [NV] = '{
      {2'd0, 1'b1, 5'd3,  16'h1111, 5'd3,  16'h1111, 3'd0},  // R1 global write
      {2'd0, 1'b1, 5'd0,  16'hBEEF, 5'd0,  16'h0000, 3'd0},  // R2 zero reg
      {2'd0, 1'b1, 5'd17, 16'h2222, 5'd17, 16'h2222, 3'd0},  // R3 local
      {2'd0, 1'b1, 5'd25, 16'h3333, 5'd25, 16'h3333, 3'd0},  // R3 in
      {2'd0, 1'b1, 5'd9,  16'h4444, 5'd9,  16'h4444, 3'd0},  // R4 out
      {2'd1, 1'b0, 5'd0,  16'h0000, 5'd25, 16'h4444, 3'd7},  // R4/R5 save wraps, outs -> ins
      {2'd0, 1'b0, 5'd0,  16'h0000, 5'd3,  16'h1111, 3'd7},  // R1 global in other window
      {2'd0, 1'b0, 5'd0,  16'h0000, 5'd17, 16'h0000, 3'd7},  // R3 local private
      {2'd2, 1'b0, 5'd0,  16'h0000, 5'd17, 16'h2222, 3'd0},  // R5 restore wraps
      {2'd2, 1'b0, 5'd0,  16'h0000, 5'd9,  16'h3333, 3'd1},  // R4 outs of w1 = ins of w0
      {2'd3, 1'b0, 5'd0,  16'h0100, 5'd17, 16'h0100, 3'd0},  // R6 trap pc to local 1
      {2'd0, 1'b0, 5'd0,  16'h0000, 5'd18, 16'h0104, 3'd0},  // R6 npc to local 2
      {2'd0, 1'b0, 5'd0,  16'h0000, 5'd25, 16'h3333, 3'd0},  // R6 ins untouched
      {2'd3, 1'b0, 5'd0,  16'h0200, 5'd18, 16'h0204, 3'd7},  // R6 trap wraps
      {2'd2, 1'b0, 5'd0,  16'h0000, 5'd17, 16'h0100, 3'd0}   // R6 back in w0
   };

   task automatic idle_inputs();
      wr_en = 1'b0; save_i = 1'b0; restore_i = 1'b0; trap_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      // R11 reset state
      rd_addr_a = 5'd3;
      #1;
      check("R11 cwp", DW'(cwp_o), 0);
      check("R11 reg", rd_data_a, 0);
      check("R11 flags", DW'({overflow_o, underflow_o}), 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         save_i    = (VEC[i][47:46] == 2'd1);
         restore_i = (VEC[i][47:46] == 2'd2);
         trap_i    = (VEC[i][47:46] == 2'd3);
         trap_pc   = DW'(VEC[i][39:24]);
         trap_npc  = DW'(VEC[i][39:24]) + 4;
         wr_en     = VEC[i][45];
         wr_addr   = VEC[i][44:40];
         wr_data   = DW'(VEC[i][39:24]);
         rd_addr_a = VEC[i][23:19];
         @(posedge clk);
         @(negedge clk);
         idle_inputs();
         #1;
         check($sformatf("vec%0d R1-R6 data", i), rd_data_a, DW'(VEC[i][18:3]));
         check($sformatf("vec%0d R5 cwp", i), DW'(cwp_o), DW'(VEC[i][2:0]));
      end
      // state: cwp 0, r3=1111, w0 r17=0100 r18=0104 r25=3333

      // R9 read during write returns old value
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h5555; rd_addr_a = 5'd20;
      #1;
      check("R9 old value", rd_data_a, 0);
      @(negedge clk);
      idle_inputs();
      #1;
      check("R9 new value", rd_data_a, 32'h5555);

      // R1/R2 on port B
      rd_addr_b = 5'd0;
      #1;
      check("R2 port b zero", rd_data_b, 0);
      rd_addr_b = 5'd3;
      #1;
      check("R1 port b global", rd_data_b, 32'h1111);

      // R7 save into invalid window
      @(negedge clk);
      inval_mask = 8'h80; save_i = 1'b1;
      #1;
      check("R7 overflow on save", DW'(overflow_o), 1);
      @(negedge clk);
      idle_inputs();
      #1;
      check("R7 cwp held", DW'(cwp_o), 0);
      // R7 trap into invalid window: no move, no stores
      trap_i = 1'b1; trap_pc = 32'hDEAD; trap_npc = 32'hBEEF;
      #1;
      check("R7 overflow on trap", DW'(overflow_o), 1);
      @(negedge clk);
      idle_inputs();
      inval_mask = '0;
      rd_addr_a = 5'd17;
      #1;
      check("R7 cwp held on trap", DW'(cwp_o), 0);
      save_i = 1'b1;
      @(negedge clk);
      idle_inputs();
      #1;
      check("R7 no trap store", rd_data_a, 32'h0200);
      restore_i = 1'b1;
      @(negedge clk);
      idle_inputs();

      // R8 restore into invalid window
      inval_mask = 8'h02; restore_i = 1'b1;
      #1;
      check("R8 underflow", DW'(underflow_o), 1);
      check("R8 no overflow", DW'(overflow_o), 0);
      @(negedge clk);
      idle_inputs();
      inval_mask = '0;
      #1;
      check("R8 cwp held", DW'(cwp_o), 0);

      // R10 save beats restore
      save_i = 1'b1; restore_i = 1'b1;
      #1;
      check("R10 no flag", DW'({overflow_o, underflow_o}), 0);
      @(negedge clk);
      idle_inputs();
      #1;
      check("R10 save wins", DW'(cwp_o), 7);
      // R10 trap beats restore, stores in w6
      trap_i = 1'b1; restore_i = 1'b1; trap_pc = 32'h0300; trap_npc = 32'h0304;
      @(negedge clk);
      idle_inputs();
      rd_addr_a = 5'd17;
      #1;
      check("R10 trap wins cwp", DW'(cwp_o), 6);
      check("R10 trap store", rd_data_a, 32'h0300);
      // R10 trap under blocked target still has priority over restore
      inval_mask = 8'h20; trap_i = 1'b1; restore_i = 1'b1;
      #1;
      check("R10 overflow not underflow", DW'({overflow_o, underflow_o}), 2);
      @(negedge clk);
      idle_inputs();
      inval_mask = '0;
      #1;
      check("R10 held", DW'(cwp_o), 6);

      // R11 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      rd_addr_a = 5'd3;
      #1;
      check("R11 cwp after reset", DW'(cwp_o), 0);
      check("R11 global cleared", rd_data_a, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule